// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block picks where each of the two ALU operands in the execute stage of a five-stage in-order integer pipeline comes from. An operand can come from the register file, from the result that the instruction one stage ahead has just produced (held in the execute/memory register), or from the result two stages ahead (held in the memory/writeback register). The unit compares the two source register numbers of the instruction in execute with the destination register numbers of the two older instructions. It emits one 2-bit select per operand that drives the operand muxes next to it.

The unit is purely combinational, with no clock and no reset. An older instruction acts as a forwarding source only if it writes a register and its destination is not register zero. When both older instructions write the consumer's source register, the younger one wins, so a chain of writes to one register always delivers the newest value. The operand muxes, the register file, load-use stall detection and branch operand forwarding in decode are all outside this block.

Top module: `fwd_unit`

## Requirements
- R1: Each select uses the encoding 2'b00 = register file, 2'b10 = execute/memory result, 2'b01 = memory/writeback result. The value 2'b11 never appears. With no qualifying producer, both selects read 2'b00.
- R2: A select reads 2'b10 when the execute/memory stage has its write flag set, has a nonzero destination, and that destination equals the operand's source register.
- R3: A select reads 2'b01 when the memory/writeback stage has its write flag set, has a nonzero destination equal to the operand's source register, and R2's condition is false for that operand.
- R4: When both stages qualify for the same operand, the select reads 2'b10.
- R5: A destination of register 0 never produces a forwarding select, even with the write flag set.
- R6: A stage whose write flag is clear is never a forwarding source, whatever its destination.
- R7: Operand A is judged only against `ex_rs` and drives `sel_a`. Operand B is judged only against `ex_rt` and drives `sel_b`. The two are decided independently, so they may pick different sources.
- R8: In a stream of ALU instructions, including three or more back-to-back writes to one register, the operand chosen by the selects always equals the architecturally newest value of the source register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | 5 | First source register number of the instruction in execute (operand A) |
| ex_rt | input | 5 | Second source register number of the instruction in execute (operand B) |
| em_dst | input | 5 | Destination register of the instruction in the execute/memory register |
| em_wr | input | 1 | Register-write flag of the instruction in the execute/memory register |
| mw_dst | input | 5 | Destination register of the instruction in the memory/writeback register |
| mw_wr | input | 1 | Register-write flag of the instruction in the memory/writeback register |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Both older stages match the same operand. A design with the priority reversed would hand the consumer a stale value, and this shows up most clearly in a triple write to one register.
- A producer targets register zero with its write flag set. A design that omitted the zero test would forward a value that should have been discarded.
- A stage has its write flag clear but a matching destination. A design that skipped the flag would forward from a store or a no-op.
- The two operands call for different sources, or a source register is named by only one of them. A design that crossed or shared the comparisons would return the wrong select on one operand.
- Random streams over a small register set are run through a reference pipeline model. These catch any combination the directed vectors miss, because the value chosen through the selects must equal the newest architectural value.

// File: rtl/fwd_pkg.sv
// Package: shared constants and the select encoding for the forwarding unit.
// Assumes register numbers fit in REG_W bits and that register 0 is hard-wired.
package fwd_pkg;
    localparam int SEL_W = 2;

    // Operand source select; the bit pattern is decoded by the operand muxes.
    typedef enum logic [SEL_W-1:0] {
        SEL_RF = 2'b00,
        SEL_MW = 2'b01,
        SEL_EM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_src_match.sv
// Module: fwd_src_match
// Says whether one older pipeline stage is a valid forwarding source for one
// operand. Assumes register 0 reads as zero, so it is never a source.
module fwd_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    // Qualified match: stage writes, target is not register 0, numbers equal.
    always_comb begin
        hit = wr && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Module: fwd_operand_sel
// Picks the source of one ALU operand. The execute/memory stage outranks the
// memory/writeback stage because it holds the younger, newer result.
// Assumes both older stages carry only ALU producers (load-use is handled elsewhere).
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] em_dst,
    input  logic             em_wr,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wr,
    output fwd_sel_e         sel
);
    logic em_hit;
    logic mw_hit;

    fwd_src_match #(.REG_W(REG_W)) u_em_match (
        .src (src),
        .dst (em_dst),
        .wr  (em_wr),
        .hit (em_hit)
    );

    fwd_src_match #(.REG_W(REG_W)) u_mw_match (
        .src (src),
        .dst (mw_dst),
        .wr  (mw_wr),
        .hit (mw_hit)
    );

    // Priority choice: younger producer first, then older, else register file.
    always_comb begin
        if (em_hit) begin
            sel = SEL_EM;
        end else if (mw_hit) begin
            sel = SEL_MW;
        end else begin
            sel = SEL_RF;
        end
    end
endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit (top)
// Forwarding select generator for the two execute-stage ALU operands.
// Purely combinational: no clock, no reset. Operand A follows ex_rs and
// operand B follows ex_rt; one selector instance per operand.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] em_dst,
    input  logic             em_wr,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wr,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b
);
    localparam int NUM_OPS = 2;

    logic [REG_W-1:0] op_src [NUM_OPS];
    fwd_sel_e         op_sel [NUM_OPS];

    // Gather the per-operand source register numbers.
    always_comb begin
        op_src[0] = ex_rs;
        op_src[1] = ex_rt;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_operand_sel #(.REG_W(REG_W)) u_sel (
            .src    (op_src[g]),
            .em_dst (em_dst),
            .em_wr  (em_wr),
            .mw_dst (mw_dst),
            .mw_wr  (mw_wr),
            .sel    (op_sel[g])
        );
    end

    // Present the selects as plain vectors at the ports.
    always_comb begin
        sel_a = op_sel[0];
        sel_b = op_sel[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
// Module: fwd_unit_chk
// Port-level checker for fwd_unit, attached by bind. Uses immediate
// assertions because the unit has no clock. Skips any input pattern that
// still holds unknown bits.
module fwd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_rs,
    input logic [REG_W-1:0] ex_rt,
    input logic [REG_W-1:0] em_dst,
    input logic             em_wr,
    input logic [REG_W-1:0] mw_dst,
    input logic             mw_wr,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b
);
    logic known;

    // Only judge fully resolved input/output values.
    always_comb begin
        known = !$isunknown({ex_rs, ex_rt, em_dst, em_wr, mw_dst, mw_wr, sel_a, sel_b});
    end

    // Relate each select to the stage fields that may justify it.
    always_comb begin
        if (known) begin
            a_r1_no_illegal_code: assert (sel_a != 2'b11 && sel_b != 2'b11)
                else $error("select code 11 seen");
            a_r2_em_justified: assert ((sel_a != 2'b10 || (em_wr && em_dst != '0 && em_dst == ex_rs)) &&
                                       (sel_b != 2'b10 || (em_wr && em_dst != '0 && em_dst == ex_rt)))
                else $error("execute/memory select without a qualifying producer");
            a_r3_mw_justified: assert ((sel_a != 2'b01 || (mw_wr && mw_dst != '0 && mw_dst == ex_rs)) &&
                                       (sel_b != 2'b01 || (mw_wr && mw_dst != '0 && mw_dst == ex_rt)))
                else $error("memory/writeback select without a qualifying producer");
            a_r4_younger_wins: assert ((sel_a != 2'b01 || !(em_wr && em_dst != '0 && em_dst == ex_rs)) &&
                                       (sel_b != 2'b01 || !(em_wr && em_dst != '0 && em_dst == ex_rt)))
                else $error("older result chosen over younger one");
            if (em_dst == '0 && mw_dst == '0) begin
                a_r5_zero_never: assert (sel_a == 2'b00 && sel_b == 2'b00)
                    else $error("register 0 destination forwarded");
            end
            if (!em_wr && !mw_wr) begin
                a_r6_no_writer: assert (sel_a == 2'b00 && sel_b == 2'b00)
                    else $error("non-writing stage forwarded");
            end
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_fwd_unit.sv
// Bench for fwd_unit: a vector table, then a reference pipeline model
// driven by directed and random ALU instruction streams.
module tb_fwd_unit;
    localparam int REG_W = 5;
    localparam int NREG  = 32;
    localparam int NVEC  = 13;
    localparam int NRAND = 300;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [REG_W-1:0] ex_rs, ex_rt, em_dst, mw_dst;
    logic             em_wr, mw_wr;
    logic [1:0]       sel_a, sel_b;

    fwd_unit #(.REG_W(REG_W)) dut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .em_dst(em_dst), .em_wr(em_wr),
        .mw_dst(mw_dst), .mw_wr(mw_wr), .sel_a(sel_a), .sel_b(sel_b)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Row: {rs, rt, em_dst, em_wr, mw_dst, mw_wr, exp_a, exp_b}
    localparam logic [25:0] VEC [NVEC] = '{
        {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00},  // R1 no match
        {5'd5,  5'd6,  5'd5,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00},  // R2 A from em
        {5'd5,  5'd6,  5'd6,  1'b1, 5'd9,  1'b0, 2'b00, 2'b10},  // R2 B from em
        {5'd7,  5'd8,  5'd0,  1'b0, 5'd7,  1'b1, 2'b01, 2'b00},  // R3 A from mw
        {5'd7,  5'd8,  5'd3,  1'b1, 5'd8,  1'b1, 2'b00, 2'b01},  // R3 B from mw
        {5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 2'b10, 2'b10},  // R4 both match
        {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},  // R5 r0 everywhere
        {5'd0,  5'd4,  5'd0,  1'b1, 5'd4,  1'b1, 2'b00, 2'b01},  // R5 r0 em skipped
        {5'd3,  5'd3,  5'd3,  1'b0, 5'd3,  1'b0, 2'b00, 2'b00},  // R6 no writers
        {5'd3,  5'd4,  5'd3,  1'b0, 5'd3,  1'b1, 2'b01, 2'b00},  // R6 em not writing
        {5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 2'b10, 2'b01},  // R7 split sources
        {5'd12, 5'd12, 5'd31, 1'b1, 5'd12, 1'b1, 2'b01, 2'b01},  // R3 both from mw
        {5'd31, 5'd2,  5'd31, 1'b1, 5'd2,  1'b1, 2'b10, 2'b01}   // R7 top register
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2";
            3, 4, 11: return "R3";
            5:       return "R4";
            6, 7:    return "R5";
            8, 9:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference pipeline model state
    logic [31:0] arch [NREG];
    logic [31:0] rf   [NREG];
    logic [REG_W-1:0] p_ex_rs, p_ex_rt, p_ex_dst, p_em_dst, p_mw_dst;
    logic p_ex_wr, p_em_wr, p_mw_wr;
    logic [31:0] p_ex_val, p_em_val, p_mw_val, p_exp_a, p_exp_b;
    logic [31:0] next_val;

    function automatic logic [31:0] pick(logic [1:0] s, logic [REG_W-1:0] r);
        case (s)
            2'b10:   return p_em_val;
            2'b01:   return p_mw_val;
            2'b00:   return rf[r];
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // Advance the model by one instruction, drive the ports, check the picks.
    task automatic push(logic [REG_W-1:0] dst, logic [REG_W-1:0] rs,
                        logic [REG_W-1:0] rt, logic wr, string tag);
        @(posedge clk);
        if (p_mw_wr && p_mw_dst != '0) rf[p_mw_dst] = p_mw_val;
        p_mw_dst = p_em_dst; p_mw_wr = p_em_wr; p_mw_val = p_em_val;
        p_em_dst = p_ex_dst; p_em_wr = p_ex_wr; p_em_val = p_ex_val;
        p_ex_dst = dst; p_ex_rs = rs; p_ex_rt = rt; p_ex_wr = wr;
        next_val = next_val + 32'd1;
        p_ex_val = next_val;
        p_exp_a = arch[rs];
        p_exp_b = arch[rt];
        if (wr && dst != '0) arch[dst] = next_val;
        ex_rs = p_ex_rs; ex_rt = p_ex_rt;
        em_dst = p_em_dst; em_wr = p_em_wr;
        mw_dst = p_mw_dst; mw_wr = p_mw_wr;
        @(negedge clk);
        check(tag, pick(sel_a, p_ex_rs), p_exp_a, "operand A value");
        check(tag, pick(sel_b, p_ex_rt), p_exp_b, "operand B value");
    endtask

    initial begin
        ex_rs = '0; ex_rt = '0; em_dst = '0; em_wr = 1'b0; mw_dst = '0; mw_wr = 1'b0;
        for (int i = 0; i < NREG; i++) begin arch[i] = '0; rf[i] = '0; end
        p_ex_rs = '0; p_ex_rt = '0; p_ex_dst = '0; p_em_dst = '0; p_mw_dst = '0;
        p_ex_wr = 1'b0; p_em_wr = 1'b0; p_mw_wr = 1'b0;
        p_ex_val = '0; p_em_val = '0; p_mw_val = '0; p_exp_a = '0; p_exp_b = '0;
        next_val = 32'h100;

        // Idle state after start-up: nothing writes, both selects read the register file (R1)
        @(negedge clk);
        check("R1", {30'd0, sel_a}, 32'd0, "idle sel_a");
        check("R1", {30'd0, sel_b}, 32'd0, "idle sel_b");

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            {ex_rs, ex_rt, em_dst, em_wr, mw_dst, mw_wr} = VEC[i][25:4];
            @(negedge clk);
            check(vec_tag(i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]}, $sformatf("vector %0d sel_a", i));
            check(vec_tag(i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]}, $sformatf("vector %0d sel_b", i));
        end

        // R8 triple write to r1 followed by a consumer of r1 on both operands
        push(5'd1, 5'd2, 5'd3, 1'b1, "R8");
        push(5'd1, 5'd1, 5'd2, 1'b1, "R8");
        push(5'd1, 5'd1, 5'd1, 1'b1, "R8");
        push(5'd4, 5'd1, 5'd1, 1'b1, "R8");
        check("R8", {30'd0, sel_a}, 32'd2, "triple-write consumer sel_a");
        // R5 writes to r0 never reach a consumer of r0
        push(5'd0, 5'd1, 5'd2, 1'b1, "R5");
        push(5'd0, 5'd0, 5'd0, 1'b1, "R5");
        push(5'd3, 5'd0, 5'd0, 1'b1, "R5");
        // R6 non-writing producers ignored
        push(5'd2, 5'd1, 5'd1, 1'b0, "R6");
        push(5'd5, 5'd2, 5'd2, 1'b1, "R6");

        // R8 random streams over a small register set
        for (int k = 0; k < NRAND; k++) begin
            push(REG_W'($urandom_range(3, 0)), REG_W'($urandom_range(3, 0)),
                 REG_W'($urandom_range(3, 0)), ($urandom_range(3, 0) != 0), "R8");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule